// File: doc/BRIEF.md
# Registered Bidirectional Bus Transceiver

This block links two bidirectional data ports, A and B. Each direction has its own storage register and its own capture clock. The A-to-B register samples port A, and the B-to-A register samples port B. Each register captures on every rising edge of its clock, whatever the enable and direction inputs are doing.

In each direction a select input picks the value that goes out. It is either the live value arriving on the opposite port or the value held in that direction's register. The value driven out is always the bitwise complement of the selected source.

An active-low enable and a direction input decide which port, if either, is driven. Each port is modelled as three separate vectors: an input, an output and a per-bit output enable. A pad ring or a wrapper can then build the tri-state buffers.

Top module: `reg_bus_xcvr`

## Requirements
- R1: On every rising edge of `clk_ab` with `rst` low, the A-to-B register stores `a_in`. This happens for every value of `oe_n` and `dir`.
- R2: On every rising edge of `clk_ba` with `rst` low, the B-to-A register stores `b_in`. This happens for every value of `oe_n` and `dir`.
- R3: With `sel_ab` = 0, `b_out` equals `~a_in` in the same cycle, with no register on the path.
- R4: With `sel_ab` = 1, `b_out` equals the complement of the A-to-B register contents.
- R5: With `sel_ba` = 0, `a_out` equals `~b_in` in the same cycle, with no register on the path.
- R6: With `sel_ba` = 1, `a_out` equals the complement of the B-to-A register contents.
- R7: With `rst` low, `oe_n` = 0 and `dir` = 1, `b_oe` is all ones and `a_oe` is all zeros.
- R8: With `rst` low, `oe_n` = 0 and `dir` = 0, `a_oe` is all ones and `b_oe` is all zeros.
- R9: With `oe_n` = 1, both `a_oe` and `b_oe` are all zeros (isolation). Both registers still capture during isolation.
- R10: A rising edge of a register's clock while `rst` is high clears that register to zero, so the stored path then drives all ones. While `rst` is high, both enable vectors are all zeros.
- R11: `a_oe` and `b_oe` never have set bits at the same time.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_ab | input | 1 | Capture clock of the A-to-B register |
| clk_ba | input | 1 | Capture clock of the B-to-A register |
| rst | input | 1 | Synchronous active-high reset, sampled by each capture clock |
| oe_n | input | 1 | Active-low drive enable |
| dir | input | 1 | 1: drive port B, 0: drive port A |
| sel_ab | input | 1 | Source for port B: 0 live A, 1 stored A-to-B register |
| sel_ba | input | 1 | Source for port A: 0 live B, 1 stored B-to-A register |
| a_in | input | W | Value arriving on port A |
| a_out | output | W | Inverted value offered to port A |
| a_oe | output | W | Per-bit drive enable for port A |
| b_in | input | W | Value arriving on port B |
| b_out | output | W | Inverted value offered to port B |
| b_oe | output | W | Per-bit drive enable for port B |

## Verification
A capture edge can land while the same direction's port is being driven from the stored path. It can also land while the opposite port is driving, or while the block is isolated. The bench provokes this by sweeping every combination of enable, direction and both selects across all 256 port-A values, with a computed port-B pattern. In each step it pulses one of the two capture clocks. Outputs are judged both before and after the pulse against a bench-side model of the two registers. The second sample must show the newly captured value, inverted, only on the stored path that changed.

// File: rtl/xcvr_pkg.sv
package xcvr_pkg;
  typedef enum logic {
    SRC_LIVE   = 1'b0,
    SRC_STORED = 1'b1
  } src_e;
endpackage

// File: rtl/xcvr_store.sv
module xcvr_store #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (rst) q <= '0;
    else     q <= d;
  end
endmodule

// File: rtl/xcvr_path.sv
module xcvr_path
  import xcvr_pkg::*;
#(
  parameter int W      = 8,
  parameter bit INVERT = 1'b1
) (
  input  logic [W-1:0] live,
  input  logic [W-1:0] stored,
  input  src_e         sel,
  output logic [W-1:0] y
);
  logic [W-1:0] pick;

  always_comb begin
    pick = (sel == SRC_STORED) ? stored : live;
  end

  generate
    if (INVERT) begin : g_inv
      assign y = ~pick;
    end else begin : g_pass
      assign y = pick;
    end
  endgenerate
endmodule

// File: rtl/xcvr_drive.sv
module xcvr_drive #(
  parameter int W = 8
) (
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  output logic [W-1:0] a_oe,
  output logic [W-1:0] b_oe
);
  logic en;

  always_comb begin
    en   = !rst && !oe_n;
    a_oe = {W{en && !dir}};
    b_oe = {W{en &&  dir}};
  end
endmodule

// File: rtl/reg_bus_xcvr.sv
module reg_bus_xcvr
  import xcvr_pkg::*;
#(
  parameter int W = 8
) (
  input  logic         clk_ab,
  input  logic         clk_ba,
  input  logic         rst,
  input  logic         oe_n,
  input  logic         dir,
  input  logic         sel_ab,
  input  logic         sel_ba,
  input  logic [W-1:0] a_in,
  output logic [W-1:0] a_out,
  output logic [W-1:0] a_oe,
  input  logic [W-1:0] b_in,
  output logic [W-1:0] b_out,
  output logic [W-1:0] b_oe
);
  logic [W-1:0] q_ab;
  logic [W-1:0] q_ba;

  xcvr_store #(.W(W)) u_store_ab (.clk(clk_ab), .rst(rst), .d(a_in), .q(q_ab));
  xcvr_store #(.W(W)) u_store_ba (.clk(clk_ba), .rst(rst), .d(b_in), .q(q_ba));

  xcvr_path #(.W(W), .INVERT(1'b1)) u_path_b (
    .live(a_in), .stored(q_ab), .sel(src_e'(sel_ab)), .y(b_out)
  );
  xcvr_path #(.W(W), .INVERT(1'b1)) u_path_a (
    .live(b_in), .stored(q_ba), .sel(src_e'(sel_ba)), .y(a_out)
  );

  xcvr_drive #(.W(W)) u_drive (
    .rst(rst), .oe_n(oe_n), .dir(dir), .a_oe(a_oe), .b_oe(b_oe)
  );
endmodule

// File: rtl/xcvr_checker.sv
module xcvr_checker #(
  parameter int W = 8
) (
  input logic         clk_ab,
  input logic         clk_ba,
  input logic         rst,
  input logic         oe_n,
  input logic         dir,
  input logic         sel_ab,
  input logic         sel_ba,
  input logic [W-1:0] a_in,
  input logic [W-1:0] a_out,
  input logic [W-1:0] a_oe,
  input logic [W-1:0] b_in,
  input logic [W-1:0] b_out,
  input logic [W-1:0] b_oe
);
  // R1 / R4: stored path on B shows complement of A captured at previous edge
  p_cap_ab_r1: assert property (@(posedge clk_ab) disable iff (rst)
    (sel_ab && !$past(rst)) |-> (b_out == ~$past(a_in)));

  // R2 / R6: stored path on A shows complement of B captured at previous edge
  p_cap_ba_r2: assert property (@(posedge clk_ba) disable iff (rst)
    (sel_ba && !$past(rst)) |-> (a_out == ~$past(b_in)));

  // R3
  p_live_ab_r3: assert property (@(posedge clk_ab) disable iff (rst)
    !sel_ab |-> (b_out == ~a_in));

  // R5
  p_live_ba_r5: assert property (@(posedge clk_ba) disable iff (rst)
    !sel_ba |-> (a_out == ~b_in));

  // R7
  p_drive_b_r7: assert property (@(posedge clk_ab) disable iff (rst)
    (!oe_n && dir) |-> (b_oe == '1 && a_oe == '0));

  // R8
  p_drive_a_r8: assert property (@(posedge clk_ba) disable iff (rst)
    (!oe_n && !dir) |-> (a_oe == '1 && b_oe == '0));

  // R9
  p_isolate_r9: assert property (@(posedge clk_ab)
    oe_n |-> (a_oe == '0 && b_oe == '0));

  // R10
  p_rst_quiet_r10: assert property (@(posedge clk_ba)
    rst |-> (a_oe == '0 && b_oe == '0));

  // R11
  always_comb begin
    p_one_side_r11: assert (!((|a_oe) && (|b_oe)));
  end
endmodule

bind reg_bus_xcvr xcvr_checker #(.W(W)) u_chk (
  .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
  .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
  .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
);

// File: tb/tb_reg_bus_xcvr.sv
module tb_reg_bus_xcvr;
  localparam int W = 8;

  logic clk = 1'b0;
  logic clk_ab = 1'b0, clk_ba = 1'b0, rst = 1'b1;
  logic oe_n = 1'b1, dir = 1'b0, sel_ab = 1'b0, sel_ba = 1'b0;
  logic [W-1:0] a_in = '0, b_in = '0;
  logic [W-1:0] a_out, a_oe, b_out, b_oe;

  logic [W-1:0] m_ab = '0, m_ba = '0;
  int checks = 0, failures = 0;

  always #10 clk = ~clk;

  reg_bus_xcvr #(.W(W)) dut (
    .clk_ab(clk_ab), .clk_ba(clk_ba), .rst(rst), .oe_n(oe_n), .dir(dir),
    .sel_ab(sel_ab), .sel_ba(sel_ba), .a_in(a_in), .a_out(a_out), .a_oe(a_oe),
    .b_in(b_in), .b_out(b_out), .b_oe(b_oe)
  );

  task automatic chk(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic check_all();
    logic [W-1:0] eb, ea, eoa, eob;
    eb  = sel_ab ? ~m_ab : ~a_in;
    ea  = sel_ba ? ~m_ba : ~b_in;
    eoa = (!rst && !oe_n && !dir) ? '1 : '0;
    eob = (!rst && !oe_n &&  dir) ? '1 : '0;
    chk(sel_ab ? "R4/R1 b_out stored" : "R3 b_out live", b_out, eb);
    chk(sel_ba ? "R6/R2 a_out stored" : "R5 a_out live", a_out, ea);
    chk(oe_n ? "R9 a_oe isolate" : (dir ? "R7 a_oe" : "R8 a_oe"), a_oe, eoa);
    chk(oe_n ? "R9 b_oe isolate" : (dir ? "R7 b_oe" : "R8 b_oe"), b_oe, eob);
    chk("R11 one side", {{(W-1){1'b0}}, ((|a_oe) && (|b_oe))}, '0);
  endtask

  task automatic pulse_ab();
    @(negedge clk); clk_ab = 1'b1; m_ab = rst ? '0 : a_in;
    @(negedge clk); clk_ab = 1'b0;
  endtask

  task automatic pulse_ba();
    @(negedge clk); clk_ba = 1'b1; m_ba = rst ? '0 : b_in;
    @(negedge clk); clk_ba = 1'b0;
  endtask

  task automatic summary();
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  endtask

  task automatic reset_check();
    rst = 1'b1; oe_n = 1'b0; a_in = 8'h5A; b_in = 8'hA5;
    pulse_ab(); pulse_ba();
    dir = 1'b1; #2;
    chk("R10 a_oe in reset", a_oe, '0);
    chk("R10 b_oe in reset", b_oe, '0);
    dir = 1'b0; #2;
    chk("R10 a_oe in reset", a_oe, '0);
    chk("R10 b_oe in reset", b_oe, '0);
    @(negedge clk); rst = 1'b0; sel_ab = 1'b1; sel_ba = 1'b1; oe_n = 1'b1; #2;
    chk("R10 b_out cleared", b_out, '1);
    chk("R10 a_out cleared", a_out, '1);
  endtask

  initial begin
    #(200000 * 20);
    checks++; failures++;
    $display("FAIL watchdog expired actual=hung expected=done");
    summary();
  end

  initial begin
    repeat (2) @(negedge clk);
    reset_check();
    for (int mode = 0; mode < 16; mode++) begin
      for (int v = 0; v < 256; v++) begin
        @(negedge clk);
        {oe_n, dir, sel_ab, sel_ba} = mode[3:0];
        a_in = v[W-1:0];
        b_in = 8'(v * 37 + mode * 11 + 3);
        #2; check_all();
        if (v[0]) pulse_ab(); else pulse_ba();
        #2; check_all();
      end
    end
    reset_check();
    summary();
  end
endmodule